// File: doc/BRIEF.md
# 4x4 Integer Inverse Transform and Reconstruction Unit

This block turns one 4x4 block of signed residual coefficients and a matching 4x4 block of 8-bit prediction samples into 16 reconstructed 8-bit pixels. Both blocks are loaded in parallel with a single start strobe. A per-block nonzero-coefficient count and an intra/inter flag choose one of three paths:

- The skip path passes the prediction through unchanged.
- The DC-only path adds one rounded offset to every pixel.
- The full path runs a separable two-pass integer inverse transform, then rounds, scales, adds the prediction and clamps.

The result leaves the block as a stream of 16 pixels in raster order with a valid flag and an index. A one-cycle done pulse follows the last pixel. Every path has the same latency, and a new block is taken only while the unit is idle.

Top module: `recon4x4`

## Requirements
- R1: While reset is asserted and right after it is released, ready_o is 1, pix_valid_o is 0 and done_o is 0.
- R2: A start_i sampled high while ready_o is 1 loads the block. Coefficient k = 4*row+col sits at coef_i[16k +: 16] and prediction sample k at pred_i[8k +: 8]. pix_valid_o is high from the second rising edge after the loading edge for 16 cycles. pix_idx_o steps 0..15 over those cycles and names the raster position k of pix_o.
- R3: done_o is high for exactly the one cycle after the pixel with index 15, and ready_o is high again in the cycle after that.
- R4: The full path first applies a 4-point butterfly to each row (inputs a,b,c,d = columns 0..3) and then to each column (inputs = rows 0..3). The butterfly computes s0=a+c, s1=a-c, s2=(b>>>1)-d, s3=b+(d>>>1) and outputs s0+s3, s1+s2, s1-s2, s0-s3 in that order. All arithmetic wraps at 16 bits.
- R5: On the full path, 32 is added (with 16-bit wrap) to the first input of every column butterfly. Each column output is shifted right arithmetically by 6, added to its prediction sample and clamped to 0..255.
- R6: The skip path is taken when the count is 0 and either the block is inter or coefficient 0 is zero. It outputs the prediction unchanged, whatever the other coefficients hold.
- R7: For an inter block with count 1 and a nonzero coefficient 0, every pixel becomes pred + dc with dc = (coef0 + 32) >>> 6, computed without wrap. The offset is applied as a saturating add of max(dc,0) followed by a saturating subtract of max(-dc,0), and the other coefficients are ignored.
- R8: An intra block with count 0 and a nonzero coefficient 0 takes the DC path of R7. An intra block with a count of 1 or more takes the full path.
- R9: An inter block takes the full path when its count is 1 and coefficient 0 is zero, and whenever its count is 2 or more.
- R10: A start_i seen while ready_o is 0 has no effect. The stream in flight keeps the values of the block already loaded, and no extra block follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load strobe, taken only when ready_o is 1 |
| intra_i | input | 1 | 1 = intra block, 0 = inter block |
| nnz_i | input | 5 | Nonzero-coefficient count of the block |
| coef_i | input | 256 | Sixteen signed 16-bit coefficients, index 4*row+col |
| pred_i | input | 128 | Sixteen unsigned 8-bit prediction samples, index 4*row+col |
| ready_o | output | 1 | Idle, able to take a block |
| pix_valid_o | output | 1 | pix_o carries a reconstructed pixel |
| pix_idx_o | output | 4 | Raster index of the pixel on pix_o |
| pix_o | output | 8 | Reconstructed pixel |
| done_o | output | 1 | One-cycle pulse after the last pixel |

## Verification
A block loaded at one rising edge shows pixel 0 after the second edge that follows. Pixel i then appears i cycles later, done_o arrives 16 cycles after pixel 0, and ready_o returns one cycle after done_o. These delays are the same on the skip, DC and full paths. The bench drives inputs on falling edges and waits exactly three falling edges after the loading edge before it samples pixel 0. It then samples one pixel per falling edge, checks done_o and ready_o at the two falling edges that follow, and compares every pixel with an arithmetic model of the selected path.

// File: rtl/recon4x4_pkg.sv
package recon4x4_pkg;
  localparam int BLK_N   = 4;
  localparam int BLK_PIX = BLK_N * BLK_N;
  localparam int IDX_W   = $clog2(BLK_PIX);

  typedef enum logic [2:0] {ST_IDLE, ST_ROW, ST_COL, ST_OUT, ST_DONE} st_e;
  typedef enum logic [1:0] {PATH_SKIP, PATH_DC, PATH_FULL} path_e;
endpackage

// File: rtl/recon4x4_butterfly.sv
module recon4x4_butterfly #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  input  logic signed [W-1:0] c_i,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] y0_o,
  output logic signed [W-1:0] y1_o,
  output logic signed [W-1:0] y2_o,
  output logic signed [W-1:0] y3_o
);
  logic signed [W-1:0] s0, s1, s2, s3;

  assign s0 = a_i + c_i;
  assign s1 = a_i - c_i;
  assign s2 = (b_i >>> 1) - d_i;
  assign s3 = b_i + (d_i >>> 1);

  assign y0_o = s0 + s3;
  assign y1_o = s1 + s2;
  assign y2_o = s1 - s2;
  assign y3_o = s0 - s3;
endmodule

// File: rtl/recon4x4_pixel.sv
module recon4x4_pixel import recon4x4_pkg::*; #(
  parameter int CW    = 16,
  parameter int PW    = 8,
  parameter int SHIFT = 6
) (
  input  path_e               path_i,
  input  logic signed [CW-1:0] res_i,
  input  logic signed [CW:0]   dc_i,
  input  logic [PW-1:0]        pred_i,
  output logic [PW-1:0]        pix_o
);
  localparam int XW = CW + 2;
  localparam logic signed [XW-1:0] MAXP = XW'((1 << PW) - 1);

  logic signed [XW-1:0] sum_s, dc_x, ndc_x;
  logic [PW-1:0] full_pix, pos_m, neg_m, up_pix, dc_pix;
  logic [PW:0]   up_sum;

  // full path: scale, add, clamp
  assign sum_s = $signed({{(XW-PW){1'b0}}, pred_i}) + XW'(res_i >>> SHIFT);

  always_comb begin
    if (sum_s < 0)         full_pix = '0;
    else if (sum_s > MAXP) full_pix = '1;
    else                   full_pix = sum_s[PW-1:0];
  end

  // dc path: split positive/negative saturating offset
  assign dc_x  = XW'(dc_i);
  assign ndc_x = -dc_x;

  always_comb begin
    pos_m = '0;
    neg_m = '0;
    if (dc_x > 0)  pos_m = (dc_x > MAXP)  ? '1 : dc_x[PW-1:0];
    if (ndc_x > 0) neg_m = (ndc_x > MAXP) ? '1 : ndc_x[PW-1:0];
  end

  assign up_sum = {1'b0, pred_i} + {1'b0, pos_m};
  assign up_pix = up_sum[PW] ? '1 : up_sum[PW-1:0];
  assign dc_pix = (up_pix > neg_m) ? (up_pix - neg_m) : '0;

  always_comb begin
    case (path_i)
      PATH_DC:   pix_o = dc_pix;
      PATH_FULL: pix_o = full_pix;
      default:   pix_o = pred_i;
    endcase
  end
endmodule

// File: rtl/recon4x4.sv
module recon4x4 import recon4x4_pkg::*; #(
  parameter int CW    = 16,
  parameter int PW    = 8,
  parameter int NW    = 5,
  parameter int SHIFT = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  intra_i,
  input  logic [NW-1:0]         nnz_i,
  input  logic [BLK_PIX*CW-1:0] coef_i,
  input  logic [BLK_PIX*PW-1:0] pred_i,
  output logic                  ready_o,
  output logic                  pix_valid_o,
  output logic [IDX_W-1:0]      pix_idx_o,
  output logic [PW-1:0]         pix_o,
  output logic                  done_o
);
  localparam logic signed [CW-1:0] RND   = CW'(1 << (SHIFT - 1));
  localparam logic signed [CW:0]   RND_X = (CW + 1)'(1 << (SHIFT - 1));

  st_e              st_q;
  logic [IDX_W-1:0] cnt_q;
  path_e            path_d, path_q;
  logic signed [CW-1:0] coef0;
  logic signed [CW:0]   dc_d, dc_q;
  logic             dc_nz;

  logic signed [CW-1:0] coef_q [BLK_PIX];
  logic signed [CW-1:0] mid_d  [BLK_PIX];
  logic signed [CW-1:0] mid_q  [BLK_PIX];
  logic signed [CW-1:0] res_d  [BLK_PIX];
  logic signed [CW-1:0] col_a  [BLK_N];
  logic [PW-1:0]        pred_q [BLK_PIX];
  logic [PW-1:0]        pix_d  [BLK_PIX];
  logic [PW-1:0]        pix_q  [BLK_PIX];

  // path select
  assign coef0 = coef_i[CW-1:0];
  assign dc_nz = |coef_i[CW-1:0];
  assign dc_d  = ($signed({coef0[CW-1], coef0}) + RND_X) >>> SHIFT;

  always_comb begin
    if (nnz_i == '0)                                path_d = (intra_i && dc_nz) ? PATH_DC : PATH_SKIP;
    else if (!intra_i && nnz_i == NW'(1) && dc_nz) path_d = PATH_DC;
    else                                            path_d = PATH_FULL;
  end

  // sequencing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) st_q <= ST_ROW;
        ST_ROW:  st_q <= ST_COL;
        ST_COL: begin
          st_q  <= ST_OUT;
          cnt_q <= '0;
        end
        ST_OUT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == IDX_W'(BLK_PIX - 1)) st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // datapath registers
  always_ff @(posedge clk_i) begin
    if (st_q == ST_IDLE && start_i) begin
      for (int k = 0; k < BLK_PIX; k++) begin
        coef_q[k] <= coef_i[k*CW +: CW];
        pred_q[k] <= pred_i[k*PW +: PW];
      end
      path_q <= path_d;
      dc_q   <= dc_d;
    end
    if (st_q == ST_ROW) begin
      for (int k = 0; k < BLK_PIX; k++) mid_q[k] <= mid_d[k];
    end
    if (st_q == ST_COL) begin
      for (int k = 0; k < BLK_PIX; k++) pix_q[k] <= pix_d[k];
    end
  end

  // pass 1: rows
  for (genvar r = 0; r < BLK_N; r++) begin : g_row
    recon4x4_butterfly #(.W(CW)) u_bf (
      .a_i (coef_q[r*BLK_N + 0]),
      .b_i (coef_q[r*BLK_N + 1]),
      .c_i (coef_q[r*BLK_N + 2]),
      .d_i (coef_q[r*BLK_N + 3]),
      .y0_o(mid_d[r*BLK_N + 0]),
      .y1_o(mid_d[r*BLK_N + 1]),
      .y2_o(mid_d[r*BLK_N + 2]),
      .y3_o(mid_d[r*BLK_N + 3])
    );
  end

  // pass 2: columns, rounding folded into the first input
  for (genvar c = 0; c < BLK_N; c++) begin : g_col
    assign col_a[c] = mid_q[c] + RND;
    recon4x4_butterfly #(.W(CW)) u_bf (
      .a_i (col_a[c]),
      .b_i (mid_q[1*BLK_N + c]),
      .c_i (mid_q[2*BLK_N + c]),
      .d_i (mid_q[3*BLK_N + c]),
      .y0_o(res_d[0*BLK_N + c]),
      .y1_o(res_d[1*BLK_N + c]),
      .y2_o(res_d[2*BLK_N + c]),
      .y3_o(res_d[3*BLK_N + c])
    );
  end

  for (genvar k = 0; k < BLK_PIX; k++) begin : g_pix
    recon4x4_pixel #(.CW(CW), .PW(PW), .SHIFT(SHIFT)) u_pix (
      .path_i(path_q),
      .res_i (res_d[k]),
      .dc_i  (dc_q),
      .pred_i(pred_q[k]),
      .pix_o (pix_d[k])
    );
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign pix_valid_o = (st_q == ST_OUT);
  assign done_o      = (st_q == ST_DONE);
  assign pix_idx_o   = cnt_q;
  assign pix_o       = pix_q[cnt_q];
endmodule

// File: rtl/recon4x4_chk.sv
module recon4x4_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       ready_o,
  input logic       pix_valid_o,
  input logic [3:0] pix_idx_o,
  input logic       done_o
);
  a_r2_first_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |-> ##3 (pix_valid_o && pix_idx_o == 4'd0));

  a_r2_index_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_idx_o != 4'd15 |=> pix_valid_o && (pix_idx_o == $past(pix_idx_o) + 4'd1));

  a_r3_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_idx_o == 4'd15 |=> done_o && !pix_valid_o);

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o && !done_o);

  a_r10_busy_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ready_o, pix_valid_o, done_o}) <= 1);
endmodule

bind recon4x4 recon4x4_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ready_o    (ready_o),
  .pix_valid_o(pix_valid_o),
  .pix_idx_o  (pix_idx_o),
  .done_o     (done_o)
);

// File: tb/recon4x4_bench.sv
module recon4x4_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         intra = 1'b0;
  logic [4:0]   nnz = '0;
  logic [255:0] coef = '0;
  logic [127:0] pred = '0;
  logic         ready, pvalid, done;
  logic [3:0]   pidx;
  logic [7:0]   pix;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  recon4x4 u_recon4x4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .intra_i(intra), .nnz_i(nnz),
    .coef_i(coef), .pred_i(pred), .ready_o(ready), .pix_valid_o(pvalid),
    .pix_idx_o(pidx), .pix_o(pix), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic void bfly(input int a, input int b, input int c, input int d,
                               output int y0, output int y1, output int y2, output int y3);
    int ev, od, p, q;
    ev = a + c;  od = a - c;
    p = (b >>> 1) - d;  q = b + (d >>> 1);
    y0 = w16(ev + q);  y1 = w16(od + p);
    y2 = w16(od - p);  y3 = w16(ev - q);
  endfunction

  function automatic int clip8(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  function automatic void model(input int cf[16], input int pr[16], input bit in_intra,
                                input int cnt, output int ex[16]);
    int t[16];
    int o[16];
    int kind;  // 0 skip, 1 dc, 2 full
    int dcv;
    if (cnt == 0)                            kind = (in_intra && cf[0] != 0) ? 1 : 0;
    else if (!in_intra && cnt == 1 && cf[0] != 0) kind = 1;
    else                                     kind = 2;
    for (int r = 0; r < 4; r++)
      bfly(cf[4*r], cf[4*r+1], cf[4*r+2], cf[4*r+3], t[4*r], t[4*r+1], t[4*r+2], t[4*r+3]);
    for (int c = 0; c < 4; c++)
      bfly(w16(t[c] + 32), t[4+c], t[8+c], t[12+c], o[c], o[4+c], o[8+c], o[12+c]);
    dcv = (cf[0] + 32) >>> 6;
    for (int k = 0; k < 16; k++) begin
      case (kind)
        0: ex[k] = pr[k];
        1: ex[k] = clip8(pr[k] + dcv);
        default: ex[k] = clip8(pr[k] + (o[k] >>> 6));
      endcase
    end
  endfunction

  task automatic drive(input int cf[16], input int pr[16], input bit in_intra, input int cnt);
    for (int k = 0; k < 16; k++) begin
      coef[k*16 +: 16] = 16'(cf[k]);
      pred[k*8 +: 8]   = 8'(pr[k]);
    end
    intra = in_intra;
    nnz   = 5'(cnt);
  endtask

  task automatic run_block(input int cf[16], input int pr[16], input bit in_intra,
                           input int cnt, input string req, input bit poke);
    int ex[16];
    int junk[16];
    model(cf, pr, in_intra, cnt, ex);
    @(negedge clk);
    chk("R2", ready, 1);
    drive(cf, pr, in_intra, cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      chk("R2", pvalid, 1);
      chk("R2", pidx, i);
      chk(req, pix, ex[i]);
      if (poke && i == 2) begin
        for (int k = 0; k < 16; k++) junk[k] = 255 - pr[k];
        drive(junk, junk, ~in_intra, 7);
        start = 1'b1;
      end
      if (poke && i == 9) start = 1'b0;
      @(negedge clk);
    end
    chk("R3", done, 1);
    chk("R3", pvalid, 0);
    @(negedge clk);
    chk("R3", done, 0);
    chk("R3", ready, 1);
    if (poke) begin
      for (int j = 0; j < 4; j++) begin
        chk("R10", pvalid, 0);
        chk("R10", ready, 1);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cf[16];
    int pr[16];
    int dcs[12];

    // R1
    repeat (3) @(negedge clk);
    chk("R1", ready, 1);
    chk("R1", pvalid, 0);
    chk("R1", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ready, 1);
    chk("R1", pvalid, 0);
    chk("R1", done, 0);

    // R6 skip: inter count 0 with busy coefficients; intra count 0 with zero DC
    for (int k = 0; k < 16; k++) begin cf[k] = 1000 * (k + 1) - 7000; pr[k] = 13 * k + 40; end
    run_block(cf, pr, 1'b0, 0, "R6", 1'b0);
    cf[0] = 0;
    run_block(cf, pr, 1'b1, 0, "R6", 1'b0);

    // R7 inter DC sweep, other coefficients ignored
    dcs = '{32767, -32768, 31, 32, -32, -33, 1, -1, 16383, -16384, 95, -97};
    for (int v = -20000; v <= 20000; v += 1237) begin
      for (int k = 0; k < 16; k++) begin
        cf[k] = (k == 0) ? v : 3000 - 411 * k;
        pr[k] = (k * 17 + v) & 255;
      end
      if (cf[0] == 0) cf[0] = 5;
      run_block(cf, pr, 1'b0, 1, "R7", 1'b0);
    end
    foreach (dcs[i]) begin
      for (int k = 0; k < 16; k++) begin
        cf[k] = (k == 0) ? dcs[i] : -200 * k;
        pr[k] = (k * 16 + 3) & 255;
      end
      run_block(cf, pr, 1'b0, 1, "R7", 1'b0);
    end

    // R8 intra: count 0 with DC -> dc path; count 1 -> full (wraps at +32767)
    for (int k = 0; k < 16; k++) begin cf[k] = (k == 0) ? 32767 : 0; pr[k] = 10 * k; end
    run_block(cf, pr, 1'b1, 0, "R8", 1'b0);
    run_block(cf, pr, 1'b1, 1, "R8", 1'b0);
    for (int k = 0; k < 16; k++) cf[k] = (k == 0) ? -700 : 90 * k;
    run_block(cf, pr, 1'b1, 0, "R8", 1'b0);

    // R9 inter full path cases
    run_block(cf, pr, 1'b0, 3, "R9", 1'b0);
    for (int k = 0; k < 16; k++) cf[k] = (k == 0) ? 32767 : 0;
    run_block(cf, pr, 1'b0, 3, "R9", 1'b0);
    for (int k = 0; k < 16; k++) cf[k] = (k == 0) ? 0 : 150 - 20 * k;
    run_block(cf, pr, 1'b0, 1, "R9", 1'b0);

    // R5 rounding edge: 31 rounds to 0, 32 rounds to 1
    for (int k = 0; k < 16; k++) begin cf[k] = 0; pr[k] = 100 + k; end
    cf[0] = 31;
    run_block(cf, pr, 1'b0, 2, "R5", 1'b0);
    cf[0] = 32;
    run_block(cf, pr, 1'b0, 2, "R5", 1'b0);
    cf[0] = -33;
    run_block(cf, pr, 1'b1, 2, "R5", 1'b0);

    // R4 full transform sweep: small, medium and wrapping magnitudes
    for (int n = 0; n < 240; n++) begin
      for (int k = 0; k < 16; k++) begin
        case (n % 3)
          0: cf[k] = int'($urandom_range(600)) - 300;
          1: cf[k] = int'($urandom_range(8000)) - 4000;
          default: cf[k] = int'($urandom_range(65535)) - 32768;
        endcase
        pr[k] = int'($urandom_range(255));
      end
      run_block(cf, pr, n[0], 2 + (n % 14), "R4", 1'b0);
    end

    // R10 start while busy is ignored
    for (int k = 0; k < 16; k++) begin cf[k] = 37 * k - 250; pr[k] = 200 - 9 * k; end
    run_block(cf, pr, 1'b0, 5, "R10", 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule